// File: doc/BRIEF.md
# Reload Event Timer

An 8-bit upward counter that restarts from a software-programmed start value instead of zero each time it passes its top value. Each step of the counter comes either from a one-cycle tick strobe produced by an internal clock divider or from rising edges on an asynchronous event pin. The event pin is first brought into the clock domain through a synchronizer. Because the counter restarts from the programmed value, it wraps once every 2^W minus that value steps. The block therefore serves either as a periodic time base or as a counter that reports once a chosen number of outside events has been seen.

Each wrap raises a sticky overflow status bit. When the interrupt enable is on, the status bit drives an interrupt line. Software clears the status by reading the control register. A wrap that lands in the same cycle as that read is kept, so it is not lost. A halt input freezes all counting, so events that arrive while the chip sleeps do not advance the count.

Top module: `evt_reload_timer`

## Requirements
- R1: While counting is allowed, the counter rises by exactly one per step. The step source is chosen by control bit 2. When bit 2 is 0, the step is a high `tick_i` sampled on a clock edge. When bit 2 is 1, the step is a rising edge of `evt_i` after synchronization. An event level held high counts once, and `tick_i` is ignored in event mode.
- R2: A step taken while the count is FFh loads the counter with the reload register. A reload value N therefore gives one wrap per 256-N steps; for example, FDh gives a wrap every 3 steps.
- R3: Every wrap sets the overflow status bit, which reads as bit 7 of the control register.
- R4: `irq_o` is high exactly when the overflow status is set and the interrupt enable (control bit 1) is set.
- R5: The overflow status stays set until software reads the control register (address 0 with `reg_rd_i` high). The read clears it, unless a wrap occurs in the same cycle, in which case the status stays set.
- R6: With the enable bit (control bit 0) clear, the count does not change for any tick or event.
- R7: While `halt_i` is high, the count does not change, and events or ticks seen during halt are never counted later.
- R8: Writing the reload register (address 1) does not change the current count. The new value is used at the next wrap.
- R9: After reset, the count, the reload register, the overflow status and all control bits are zero, and `irq_o` is low.
- R10: Register map: address 0 is control/status, address 1 is reload, address 2 is the count (read only), and address 3 reads zero. Writing bit 7 of control cannot set the overflow status, and writes to address 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a read of address 0 clears the overflow status) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register (combinational) |
| tick_i | input | 1 | Internal step strobe from the clock divider |
| evt_i | input | 1 | Asynchronous external event input |
| halt_i | input | 1 | Halt request; freezes counting |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach is a wrap that coincides with the read that clears the status. A correct design must keep the status set in that case, while a careless one drops the new overflow. The stimulus selects the tick source and steps the counter one tick at a time until the count reads FFh. It then drives `tick_i` and a clearing read of address 0 in the same cycle, and expects the status to be still set afterwards and cleared only by a second read. Large event counts with a held-high event level and a reload change in mid-count are also driven, to confirm the 256-N wrap period.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;

   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL   = 2'd0,
      REG_RELOAD = 2'd1,
      REG_COUNT  = 2'd2,
      REG_NONE   = 2'd3
   } reg_sel_e;

   // control bit positions (status bit sits at the top of the data word)
   localparam int unsigned BIT_TCE = 0;
   localparam int unsigned BIT_OIE = 1;
   localparam int unsigned BIT_SRC = 2;

   typedef struct packed {
      logic src_ext;
      logic oie;
      logic tce;
   } ctrl_t;

endpackage

// File: rtl/rtimer_sync.sv
module rtimer_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rtimer_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/rtimer_count.sv
module rtimer_count #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         step_i,
   input  logic [W-1:0] reload_i,
   output logic [W-1:0] cnt_o,
   output logic         wrap_o
);

   logic [W-1:0] cnt_q;
   logic         at_top;

   assign at_top = &cnt_q;
   assign wrap_o = step_i & at_top;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= at_top ? reload_i : cnt_q + W'(1);
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/rtimer_regs.sv
module rtimer_regs
   import rtimer_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [W-1:0]      wdata_i,
   input  logic              wrap_i,
   input  logic [W-1:0]      cnt_i,
   output logic [W-1:0]      rdata_o,
   output ctrl_t             ctrl_o,
   output logic [W-1:0]      reload_o,
   output logic              ovf_o
);

   localparam int unsigned PAD_W = W - 4;

   ctrl_t        ctrl_q;
   logic [W-1:0] reload_q;
   logic         ovf_q;
   reg_sel_e     sel;

   assign sel = reg_sel_e'(addr_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q   <= '0;
         reload_q <= '0;
      end else if (wr_i) begin
         if (sel == REG_CTRL) begin
            ctrl_q.tce     <= wdata_i[BIT_TCE];
            ctrl_q.oie     <= wdata_i[BIT_OIE];
            ctrl_q.src_ext <= wdata_i[BIT_SRC];
         end
         if (sel == REG_RELOAD) begin
            reload_q <= wdata_i;
         end
      end
   end

   // a wrap wins over the clearing read in the same cycle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ovf_q <= 1'b0;
      end else if (wrap_i) begin
         ovf_q <= 1'b1;
      end else if (rd_i && sel == REG_CTRL) begin
         ovf_q <= 1'b0;
      end
   end

   always_comb begin
      unique case (sel)
         REG_CTRL:   rdata_o = {ovf_q, {PAD_W{1'b0}}, ctrl_q.src_ext, ctrl_q.oie, ctrl_q.tce};
         REG_RELOAD: rdata_o = reload_q;
         REG_COUNT:  rdata_o = cnt_i;
         default:    rdata_o = '0;
      endcase
   end

   assign ctrl_o   = ctrl_q;
   assign reload_o = reload_q;
   assign ovf_o    = ovf_q;

endmodule

// File: rtl/evt_reload_timer.sv
module evt_reload_timer
   import rtimer_pkg::*;
#(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              reg_wr_i,
   input  logic              reg_rd_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [CNT_W-1:0]  reg_wdata_i,
   output logic [CNT_W-1:0]  reg_rdata_o,
   input  logic              tick_i,
   input  logic              evt_i,
   input  logic              halt_i,
   output logic              irq_o
);

   generate
      if (CNT_W < 4) begin : g_bad_width
         $error("evt_reload_timer: CNT_W must be at least 4");
      end
   endgenerate

   logic             evt_rise;
   logic             step_w;
   logic             wrap_w;
   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] reload_w;
   logic             ovf_w;
   ctrl_t            ctrl_w;
   logic             src_step;

   rtimer_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (evt_i),
      .rise_o  (evt_rise)
   );

   assign src_step = ctrl_w.src_ext ? evt_rise : tick_i;
   assign step_w   = ctrl_w.tce & ~halt_i & src_step;

   rtimer_count #(.W(CNT_W)) count_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .step_i   (step_w),
      .reload_i (reload_w),
      .cnt_o    (cnt_w),
      .wrap_o   (wrap_w)
   );

   rtimer_regs #(.W(CNT_W)) regs_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (reg_wr_i),
      .rd_i     (reg_rd_i),
      .addr_i   (reg_addr_i),
      .wdata_i  (reg_wdata_i),
      .wrap_i   (wrap_w),
      .cnt_i    (cnt_w),
      .rdata_o  (reg_rdata_o),
      .ctrl_o   (ctrl_w),
      .reload_o (reload_w),
      .ovf_o    (ovf_w)
   );

   assign irq_o = ovf_w & ctrl_w.oie;

endmodule

// File: rtl/rtimer_chk.sv
module rtimer_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic         step,
   input logic         wrap,
   input logic [W-1:0] cnt,
   input logic [W-1:0] reload,
   input logic         ovf,
   input logic         tce,
   input logic         halt_i,
   input logic         reg_rd_i,
   input logic [1:0]   reg_addr_i
);

   logic rd_clr;
   assign rd_clr = reg_rd_i && (reg_addr_i == 2'd0);

   a_r1_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step && cnt != '1) |=> (cnt == W'($past(cnt) + 1'b1)));

   a_r1_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !step |=> $stable(cnt));

   a_r2_reload_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step && cnt == '1) |=> (cnt == $past(reload)));

   a_r3_ovf_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap |=> ovf);

   a_r5_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf && !rd_clr) |=> ovf);

   a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_clr && !wrap) |=> !ovf);

   a_r6_disabled_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tce |=> $stable(cnt));

   a_r7_halt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      halt_i |=> $stable(cnt));

endmodule

bind evt_reload_timer rtimer_chk #(.W(CNT_W)) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .step       (step_w),
   .wrap       (wrap_w),
   .cnt        (cnt_w),
   .reload     (reload_w),
   .ovf        (ovf_w),
   .tce        (ctrl_w.tce),
   .halt_i     (halt_i),
   .reg_rd_i   (reg_rd_i),
   .reg_addr_i (reg_addr_i)
);

// File: tb/evt_reload_timer_tb_top.sv
module evt_reload_timer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr = 1'b0;
   logic       rd = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       tick = 1'b0;
   logic       evt = 1'b0;
   logic       halt = 1'b0;
   logic       irq;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   evt_reload_timer dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .reg_wr_i    (wr),
      .reg_rd_i    (rd),
      .reg_addr_i  (addr),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .tick_i      (tick),
      .evt_i       (evt),
      .halt_i      (halt),
      .irq_o       (irq)
   );

   task automatic check(input string req, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, input bit clr, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd = clr;
      #1 d = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic events(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); evt = 1'b1;
         repeat (2) @(negedge clk);
         evt = 1'b0;
         repeat (2) @(negedge clk);
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      reg_read(2'd0, 1'b0, d); check("R9 ctrl", d, 8'h00);
      reg_read(2'd1, 1'b0, d); check("R9 reload", d, 8'h00);
      reg_read(2'd2, 1'b0, d); check("R9 count", d, 8'h00);
      check("R9 irq", irq, 0);
   endtask

   task automatic t_ticks;
      logic [7:0] d;
      reg_write(2'd0, 8'h01);
      ticks(5);
      reg_read(2'd2, 1'b0, d); check("R1 tick count", d, 8'h05);
      reg_write(2'd0, 8'h00);
      ticks(3);
      reg_read(2'd2, 1'b0, d); check("R6 disabled", d, 8'h05);
   endtask

   task automatic t_events;
      logic [7:0] d;
      reg_write(2'd1, 8'hFD);
      reg_read(2'd2, 1'b0, d); check("R8 reload write keeps count", d, 8'h05);
      reg_write(2'd0, 8'h05);
      events(250);
      reg_read(2'd2, 1'b0, d); check("R1 event count", d, 8'hFF);
      reg_read(2'd0, 1'b0, d); check("R3 no wrap yet", d, 8'h05);
      events(1);
      reg_read(2'd2, 1'b0, d); check("R2 reload on wrap", d, 8'hFD);
      reg_read(2'd0, 1'b1, d); check("R3 ovf set", d, 8'h85);
      check("R4 irq off without enable", irq, 0);
      reg_read(2'd0, 1'b0, d); check("R5 read cleared", d, 8'h05);
      ticks(3);
      reg_read(2'd2, 1'b0, d); check("R1 tick ignored in event mode", d, 8'hFD);
      @(negedge clk); evt = 1'b1;
      repeat (10) @(negedge clk);
      evt = 1'b0;
      repeat (3) @(negedge clk);
      reg_read(2'd2, 1'b0, d); check("R1 held level counts once", d, 8'hFE);
      events(1);
      reg_read(2'd0, 1'b0, d); check("R2 no wrap after 2", d, 8'h05);
      events(1);
      reg_read(2'd0, 1'b1, d); check("R2 wrap after 3", d, 8'h85);
      reg_write(2'd1, 8'hF0);
      reg_read(2'd2, 1'b0, d); check("R8 count unchanged", d, 8'hFD);
      events(3);
      reg_read(2'd2, 1'b0, d); check("R8 new reload used", d, 8'hF0);
   endtask

   task automatic t_irq;
      logic [7:0] d;
      reg_write(2'd0, 8'h07);
      check("R4 irq on", irq, 1);
      repeat (20) @(negedge clk);
      reg_read(2'd0, 1'b0, d); check("R5 sticky", d, 8'h87);
      reg_read(2'd0, 1'b1, d);
      check("R4 irq off after clear", irq, 0);
      reg_read(2'd0, 1'b0, d); check("R5 cleared", d, 8'h07);
   endtask

   task automatic t_halt;
      logic [7:0] d;
      halt = 1'b1;
      events(3);
      reg_read(2'd2, 1'b0, d); check("R7 events halted", d, 8'hF0);
      reg_write(2'd0, 8'h03);
      ticks(3);
      reg_read(2'd2, 1'b0, d); check("R7 ticks halted", d, 8'hF0);
      @(negedge clk); halt = 1'b0;
      ticks(2);
      reg_read(2'd2, 1'b0, d); check("R7 resume without backlog", d, 8'hF2);
   endtask

   task automatic t_same_cycle;
      logic [7:0] d;
      ticks(13);
      reg_read(2'd2, 1'b0, d); check("R5 at top", d, 8'hFF);
      @(negedge clk);
      addr = 2'd0; rd = 1'b1; tick = 1'b1;
      #1 d = rdata;
      check("R5 status before", d, 8'h03);
      @(negedge clk);
      rd = 1'b0; tick = 1'b0;
      reg_read(2'd0, 1'b0, d); check("R5 wrap beats read", d, 8'h83);
      check("R4 irq with wrap", irq, 1);
      reg_read(2'd2, 1'b0, d); check("R2 wrapped", d, 8'hF0);
      reg_read(2'd0, 1'b1, d);
      reg_read(2'd0, 1'b0, d); check("R5 second read clears", d, 8'h03);
   endtask

   task automatic t_map;
      logic [7:0] d;
      reg_write(2'd0, 8'h83);
      reg_read(2'd0, 1'b0, d); check("R10 ovf not writable", d, 8'h03);
      reg_write(2'd2, 8'h55);
      reg_read(2'd2, 1'b0, d); check("R10 count read only", d, 8'hF0);
      reg_read(2'd3, 1'b0, d); check("R10 unused address", d, 8'h00);
      reg_read(2'd1, 1'b0, d); check("R10 reload readback", d, 8'hF0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ticks();
      t_events();
      t_irq();
      t_halt();
      t_same_cycle();
      t_map();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nchk++;
         nerr++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

endmodule